// File: doc/BRIEF.md
# SPI In-System Programming Decoder

This block is the serial programming front end of a small microcontroller. While the programming reset input `prog_rst_n` is held low, it acts as an SPI slave in mode 0. It gathers four-byte instructions from `mosi`, returns a byte stream on `miso`, and applies reads, writes and a chip erase to two on-chip byte arrays: a program flash model and an EEPROM model. Both arrays come up in the erased state (0xFF).

No instruction other than the enable handshake is honoured until that handshake has completed. The enabled state is lost when `prog_rst_n` goes high or after a chip erase. Writes and the erase are self-timed. A wait counter holds `busy` high for a fixed number of clocks, and instructions that need the arrays are dropped while it runs. `sck`, `mosi` and `prog_rst_n` are asynchronous to `clk`. Each passes through a two-stage synchronizer, and SCK edges are detected in the `clk` domain, so SCK must stay well below a quarter of the `clk` rate.

Top module: `spi_isp_decoder`

## Requirements
- R1: While `prog_rst_n` is high, SCK edges are ignored, `miso` stays 0, and the bit and byte position return to the start of an instruction, so a partly shifted instruction is dropped.
- R2: An instruction is four bytes, MSB first. MOSI is sampled on the rising SCK edge and MISO changes only on the falling edge. The first and second bytes of every instruction return 0x00.
- R3: While `prog_rst_n` is low, the third returned byte of every instruction is a copy of the second byte received.
- R4: The enable instruction is 0xAC, 0x53, any, any, and it takes effect once its fourth byte has been received. Until then, reads, writes and erase do nothing: memories keep their contents and reads return 0x00.
- R5: Raising `prog_rst_n` clears the enabled state.
- R6: Flash write is 0x48, hi, lo, data. Flash read is 0x28, hi, lo, any, and the cell is returned as the fourth byte. The cell address is the low FLASH_AW bits of {hi, lo}.
- R7: EEPROM write is 0xC0, any, addr, data. EEPROM read is 0xA0, any, addr, any, and the cell is returned as the fourth byte. The cell address is the low EE_AW bits of addr.
- R8: Chip erase is 0xAC, 0x80, any, any, and it sets every cell of both arrays to 0xFF. 0xFF is also the value of every cell after `rst_n`.
- R9: An accepted chip erase clears the enabled state, so the enable instruction must be sent again.
- R10: An accepted write raises `busy` for WRITE_WAIT clocks and an accepted erase for ERASE_WAIT clocks, starting in the clock in which the last SCK rise of the fourth byte is registered. While `busy` is high, writes, erase and reads are dropped (reads return 0x00). The enable instruction is still accepted.
- R11: Any other first and second byte pair has no effect and returns 0x00 as the fourth byte.
- R12: After `rst_n`, `busy` and `miso` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| prog_rst_n | input | 1 | Programming reset; low enables serial programming |
| sck | input | 1 | SPI serial clock from the host |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| busy | output | 1 | High while a self-timed write or erase runs |

## Verification
Every input pin reaches the logic through two synchronizer flops and an edge register. A response bit therefore appears on `miso` three clocks after the SCK fall that moves it. `busy` rises three clocks after the bench raises the final SCK of a write. The bench sends each SPI half-bit as eight clocks, so it samples `miso` just before the next rising SCK, long after the value has settled. Its model schedules the busy window with the same three-clock offset and compares `busy` after every clock edge. Memory effects are observed only through later read instructions.

// File: rtl/ispd_pkg.sv
package ispd_pkg;

  typedef enum logic [2:0] {
    K_NONE,
    K_ENABLE,
    K_ERASE,
    K_RD_FL,
    K_WR_FL,
    K_RD_EE,
    K_WR_EE
  } ispd_kind_e;

  localparam logic [7:0] LEAD_CTRL   = 8'hAC;
  localparam logic [7:0] KEY_ENABLE  = 8'h53;
  localparam logic [7:0] KEY_ERASE   = 8'h80;
  localparam logic [7:0] OP_RD_FL    = 8'h28;
  localparam logic [7:0] OP_WR_FL    = 8'h48;
  localparam logic [7:0] OP_RD_EE    = 8'hA0;
  localparam logic [7:0] OP_WR_EE    = 8'hC0;
  localparam logic [7:0] ERASED_BYTE = 8'hFF;

  // Instruction class from the first two bytes.
  function automatic ispd_kind_e ispd_decode(input logic [7:0] lead, input logic [7:0] second);
    ispd_kind_e k;
    k = K_NONE;
    if (lead == LEAD_CTRL && second == KEY_ENABLE) k = K_ENABLE;
    else if (lead == LEAD_CTRL && second == KEY_ERASE) k = K_ERASE;
    else if (lead == OP_RD_FL) k = K_RD_FL;
    else if (lead == OP_WR_FL) k = K_WR_FL;
    else if (lead == OP_RD_EE) k = K_RD_EE;
    else if (lead == OP_WR_EE) k = K_WR_EE;
    return k;
  endfunction

endpackage

// File: rtl/ispd_sync.sv
module ispd_sync #(
  parameter int             W       = 1,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= RST_VAL;
      q        <= RST_VAL;
    end else begin
      stage1_q <= d;
      q        <= stage1_q;
    end
  end
endmodule

// File: rtl/ispd_shift.sv
module ispd_shift (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active,
  input  logic       sck_s,
  input  logic       mosi_s,
  input  logic [7:0] tx_byte,
  output logic       byte_done,
  output logic [1:0] byte_idx,
  output logic [7:0] rx_byte,
  output logic       miso
);
  logic       sck_d;
  logic [2:0] bit_q, bit_d;
  logic [1:0] byte_q, byte_d;
  logic [6:0] rx_q, rx_d;
  logic [7:0] tx_q, tx_d;
  logic       rise, fall;

  assign rise = active & sck_s & ~sck_d;
  assign fall = active & ~sck_s & sck_d;

  always_comb begin
    bit_d  = bit_q;
    byte_d = byte_q;
    rx_d   = rx_q;
    tx_d   = tx_q;
    if (!active) begin
      bit_d  = '0;
      byte_d = '0;
      tx_d   = '0;
    end else begin
      if (rise) begin
        rx_d  = {rx_q[5:0], mosi_s};
        bit_d = bit_q + 3'd1;
        if (bit_q == 3'd7) byte_d = byte_q + 2'd1;
      end
      if (fall) begin
        // At a byte boundary load the next response, else shift.
        tx_d = (bit_q == 3'd0) ? tx_byte : {tx_q[6:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d  <= 1'b0;
      bit_q  <= '0;
      byte_q <= '0;
      rx_q   <= '0;
      tx_q   <= '0;
    end else begin
      sck_d  <= sck_s;
      bit_q  <= bit_d;
      byte_q <= byte_d;
      rx_q   <= rx_d;
      tx_q   <= tx_d;
    end
  end

  assign byte_done = rise & (bit_q == 3'd7);
  assign byte_idx  = byte_q;
  assign rx_byte   = {rx_q, mosi_s};
  assign miso      = tx_q[7];

  // R1: leaving programming mode drops any partial instruction
  a_r1_position_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (bit_q == 3'd0 && byte_q == 2'd0));

  // R2: the output bit moves only after a falling SCK
  a_r2_miso_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && !$stable(miso)) |-> $past(fall));
endmodule

// File: rtl/ispd_mem.sv
module ispd_mem
  import ispd_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic          erase,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] cell_q [DEPTH];
  logic [7:0] cell_d [DEPTH];

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      cell_d[i] = cell_q[i];
      if (erase) cell_d[i] = ERASED_BYTE;
      else if (we && waddr == AW'(i)) cell_d[i] = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cell_q[i] <= ERASED_BYTE;
    end else begin
      for (int i = 0; i < DEPTH; i++) cell_q[i] <= cell_d[i];
    end
  end

  assign rdata = cell_q[raddr];

  // R8: an erase leaves both ends of the array erased
  a_r8_erase_fills: assert property (@(posedge clk) disable iff (!rst_n)
    erase |=> (cell_q[0] == ERASED_BYTE && cell_q[DEPTH-1] == ERASED_BYTE));

  // R6: a write lands at the addressed cell
  a_r6_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !erase) |=> (cell_q[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/ispd_cmd.sv
module ispd_cmd
  import ispd_pkg::*;
#(
  parameter int FAW        = 6,
  parameter int EAW        = 4,
  parameter int WRITE_WAIT = 600,
  parameter int ERASE_WAIT = 1500
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           active,
  input  logic           byte_done,
  input  logic [1:0]     byte_idx,
  input  logic [7:0]     rx_byte,
  input  logic [7:0]     fl_rdata,
  input  logic [7:0]     ee_rdata,
  output logic [7:0]     tx_byte,
  output logic           busy,
  output logic           fl_we,
  output logic           ee_we,
  output logic           erase,
  output logic [FAW-1:0] fl_addr,
  output logic [EAW-1:0] ee_addr,
  output logic [7:0]     wr_data
);
  localparam int MAXW = (WRITE_WAIT > ERASE_WAIT) ? WRITE_WAIT : ERASE_WAIT;
  localparam int WW   = $clog2(MAXW + 1);

  logic [7:0]  b0_q, b0_d, b1_q, b1_d, b2_q, b2_d, tx_q, tx_d;
  logic        en_q, en_d;
  logic [WW-1:0] wait_q, wait_d;
  ispd_kind_e  kind;
  logic [7:0]  lo_sel;
  logic        ok_go, fire;

  assign kind    = ispd_decode(b0_q, b1_q);
  assign busy    = (wait_q != '0);
  assign ok_go   = en_q & ~busy;
  assign fire    = byte_done & (byte_idx == 2'd3);
  // Read address uses the arriving third byte; write address its stored copy.
  assign lo_sel  = (byte_idx == 2'd2) ? rx_byte : b2_q;
  assign fl_addr = FAW'({b1_q, lo_sel});
  assign ee_addr = EAW'(lo_sel);
  assign wr_data = rx_byte;
  assign fl_we   = fire & ok_go & (kind == K_WR_FL);
  assign ee_we   = fire & ok_go & (kind == K_WR_EE);
  assign erase   = fire & ok_go & (kind == K_ERASE);

  always_comb begin
    b0_d   = b0_q;
    b1_d   = b1_q;
    b2_d   = b2_q;
    tx_d   = tx_q;
    en_d   = en_q;
    wait_d = busy ? (wait_q - 1'b1) : wait_q;
    if (!active) begin
      en_d = 1'b0;
      tx_d = '0;
    end else if (byte_done) begin
      case (byte_idx)
        2'd0: begin
          b0_d = rx_byte;
          tx_d = '0;
        end
        2'd1: begin
          b1_d = rx_byte;
          tx_d = rx_byte;
        end
        2'd2: begin
          b2_d = rx_byte;
          if (ok_go && kind == K_RD_FL)      tx_d = fl_rdata;
          else if (ok_go && kind == K_RD_EE) tx_d = ee_rdata;
          else                               tx_d = '0;
        end
        2'd3: begin
          tx_d = '0;
          if (kind == K_ENABLE) en_d = 1'b1;
          if (fl_we || ee_we) wait_d = WW'(WRITE_WAIT);
          if (erase) begin
            wait_d = WW'(ERASE_WAIT);
            en_d   = 1'b0;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b0_q   <= '0;
      b1_q   <= '0;
      b2_q   <= '0;
      tx_q   <= '0;
      en_q   <= 1'b0;
      wait_q <= '0;
    end else begin
      b0_q   <= b0_d;
      b1_q   <= b1_d;
      b2_q   <= b2_d;
      tx_q   <= tx_d;
      en_q   <= en_d;
      wait_q <= wait_d;
    end
  end

  assign tx_byte = tx_q;

  // R4: no array change unless the handshake has completed
  a_r4_change_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_we || ee_we || erase) |-> en_q);

  // R5: leaving programming mode drops the enabled state
  a_r5_idle_drops_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !en_q);

  // R9: an accepted erase drops the enabled state
  a_r9_erase_drops_enable: assert property (@(posedge clk) disable iff (!rst_n)
    erase |=> !en_q);

  // R10: a write starts the full wait window
  a_r10_write_wait_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_we || ee_we) |=> (wait_q == WW'(WRITE_WAIT)));

  // R10: the wait counter steps down by one per clock
  a_r10_wait_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fire) |=> (wait_q == WW'($past(wait_q) - 1'b1)));

  // R3: the second byte is queued as the next response
  a_r3_echo_queued: assert property (@(posedge clk) disable iff (!rst_n)
    (active && byte_done && byte_idx == 2'd1) |=> (tx_byte == $past(rx_byte)));
endmodule

// File: rtl/spi_isp_decoder.sv
module spi_isp_decoder #(
  parameter int FLASH_AW   = 6,
  parameter int EE_AW      = 4,
  parameter int WRITE_WAIT = 600,
  parameter int ERASE_WAIT = 1500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic prog_rst_n,
  input  logic sck,
  input  logic mosi,
  output logic miso,
  output logic busy
);
  logic [2:0]          pins_s;
  logic                active;
  logic                byte_done;
  logic [1:0]          byte_idx;
  logic [7:0]          rx_byte, tx_byte, fl_rdata, ee_rdata, wr_data;
  logic                fl_we, ee_we, erase;
  logic [FLASH_AW-1:0] fl_addr;
  logic [EE_AW-1:0]    ee_addr;

  ispd_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({prog_rst_n, mosi, sck}),
    .q     (pins_s)
  );

  assign active = ~pins_s[2];

  ispd_shift u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (active),
    .sck_s     (pins_s[0]),
    .mosi_s    (pins_s[1]),
    .tx_byte   (tx_byte),
    .byte_done (byte_done),
    .byte_idx  (byte_idx),
    .rx_byte   (rx_byte),
    .miso      (miso)
  );

  ispd_cmd #(
    .FAW        (FLASH_AW),
    .EAW        (EE_AW),
    .WRITE_WAIT (WRITE_WAIT),
    .ERASE_WAIT (ERASE_WAIT)
  ) u_cmd (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (active),
    .byte_done (byte_done),
    .byte_idx  (byte_idx),
    .rx_byte   (rx_byte),
    .fl_rdata  (fl_rdata),
    .ee_rdata  (ee_rdata),
    .tx_byte   (tx_byte),
    .busy      (busy),
    .fl_we     (fl_we),
    .ee_we     (ee_we),
    .erase     (erase),
    .fl_addr   (fl_addr),
    .ee_addr   (ee_addr),
    .wr_data   (wr_data)
  );

  ispd_mem #(.AW(FLASH_AW)) u_flash (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (fl_we),
    .waddr (fl_addr),
    .wdata (wr_data),
    .erase (erase),
    .raddr (fl_addr),
    .rdata (fl_rdata)
  );

  ispd_mem #(.AW(EE_AW)) u_eeprom (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (ee_we),
    .waddr (ee_addr),
    .wdata (wr_data),
    .erase (erase),
    .raddr (ee_addr),
    .rdata (ee_rdata)
  );
endmodule

// File: tb/spi_isp_decoder_tb_top.sv
module spi_isp_decoder_tb_top;
  localparam int FAW   = 6;
  localparam int EAW   = 4;
  localparam int WWAIT = 600;
  localparam int EWAIT = 1500;
  localparam int HALF  = 8;

  localparam int KN = 0, KEN = 1, KER = 2, KRF = 3, KWF = 4, KRE = 5, KWE = 6;

  logic clk, rst_n, prog_rst_n, sck, mosi, miso, busy;

  spi_isp_decoder #(
    .FLASH_AW(FAW), .EE_AW(EAW), .WRITE_WAIT(WWAIT), .ERASE_WAIT(EWAIT)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .prog_rst_n(prog_rst_n),
    .sck(sck), .mosi(mosi), .miso(miso), .busy(busy)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int tests = 0, fails = 0;
  int fl_m [1 << FAW];
  int ee_m [1 << EAW];
  bit en_m = 1'b0;
  int busy_left = 0, sched = 0, sched_len = 0;
  bit done = 1'b0;
  bit busy_on = 1'b0;

  function automatic int kind_of(input logic [7:0] a, input logic [7:0] b);
    if (a == 8'hAC && b == 8'h53) return KEN;
    if (a == 8'hAC && b == 8'h80) return KER;
    if (a == 8'h28) return KRF;
    if (a == 8'h48) return KWF;
    if (a == 8'hA0) return KRE;
    if (a == 8'hC0) return KWE;
    return KN;
  endfunction

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  // Per-clock model of the busy window (R10).
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sched > 0) begin
        sched--;
        if (sched == 0) busy_left = sched_len;
      end
      if (busy_on) begin
        tests++;
        if (busy !== (busy_left > 0)) begin
          fails++;
          $display("FAIL R10: busy got %0b expected %0b", busy, busy_left > 0);
        end
      end
      if (busy_left > 0) busy_left--;
    end
  end

  task automatic send(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                      input logic [7:0] b3, input string req);
    logic [7:0] got [4];
    logic [7:0] exp [4];
    logic [7:0] cur;
    bit act;
    bit okay;
    int k;
    act = (prog_rst_n == 1'b0);
    k = kind_of(b0, b1);
    for (int i = 0; i < 4; i++) exp[i] = 8'h00;
    for (int i = 0; i < 4; i++) begin
      cur = (i == 0) ? b0 : (i == 1) ? b1 : (i == 2) ? b2 : b3;
      for (int j = 7; j >= 0; j--) begin
        @(negedge clk);
        mosi = cur[j];
        repeat (HALF) @(negedge clk);
        got[i][j] = miso;
        okay = en_m && busy_left == 0 && sched == 0;
        if (act && i == 2 && j == 0) begin
          if (okay && k == KRF) exp[3] = 8'(fl_m[{b1, b2} & ((1 << FAW) - 1)]);
          else if (okay && k == KRE) exp[3] = 8'(ee_m[b2 & ((1 << EAW) - 1)]);
        end
        if (act && i == 3 && j == 0) begin
          if (k == KEN) en_m = 1'b1;
          else if (okay && k == KWF) begin
            fl_m[{b1, b2} & ((1 << FAW) - 1)] = b3; sched = 3; sched_len = WWAIT;
          end else if (okay && k == KWE) begin
            ee_m[b2 & ((1 << EAW) - 1)] = b3; sched = 3; sched_len = WWAIT;
          end else if (okay && k == KER) begin
            for (int m = 0; m < (1 << FAW); m++) fl_m[m] = 255;
            for (int m = 0; m < (1 << EAW); m++) ee_m[m] = 255;
            en_m = 1'b0; sched = 3; sched_len = EWAIT;
          end
        end
        sck = 1'b1;
        repeat (HALF) @(negedge clk);
        sck = 1'b0;
      end
    end
    if (act) exp[2] = b1;
    check8({"R2 first byte ", req}, got[0], exp[0]);
    check8({"R2 second byte ", req}, got[1], exp[1]);
    check8(act ? {"R3 echo ", req} : {"R1 idle ", req}, got[2], exp[2]);
    check8({"fourth byte ", req}, got[3], exp[3]);
  endtask

  task automatic set_prst(input logic v);
    @(negedge clk);
    prog_rst_n = v;
    if (v) en_m = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic wait_idle();
    while (busy_left > 0 || sched > 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    for (int m = 0; m < (1 << FAW); m++) fl_m[m] = 255;
    for (int m = 0; m < (1 << EAW); m++) ee_m[m] = 255;
    rst_n = 1'b0; prog_rst_n = 1'b1; sck = 1'b0; mosi = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    busy_on = 1'b1;
    @(negedge clk);
    check8("R12 reset busy", {7'd0, busy}, 8'h00);
    check8("R12 reset miso", {7'd0, miso}, 8'h00);

    // R1: instructions sent while prog_rst_n is high are ignored
    send(8'hAC, 8'h53, 8'h00, 8'h00, "R1 enable while high");
    set_prst(1'b0);
    send(8'h48, 8'h00, 8'h05, 8'h3C, "R4 write before enable");
    send(8'h28, 8'h00, 8'h05, 8'h00, "R4 read before enable");
    send(8'hAC, 8'h53, 8'h12, 8'h34, "R4 enable");
    send(8'h28, 8'h00, 8'h05, 8'h00, "R8 reset value flash");
    send(8'hA0, 8'h00, 8'h02, 8'h00, "R8 reset value eeprom");

    // R6: flash write and read, address aliasing
    send(8'h48, 8'h01, 8'h07, 8'h5A, "R6 flash write");
    wait_idle();
    send(8'h28, 8'h00, 8'h07, 8'h00, "R6 flash read alias");
    send(8'h48, 8'h00, 8'h3F, 8'hA5, "R6 flash write top");
    wait_idle();
    send(8'h28, 8'h00, 8'h3F, 8'h00, "R6 flash read top");

    // R7: EEPROM write and read
    send(8'hC0, 8'h00, 8'h13, 8'h77, "R7 eeprom write");
    wait_idle();
    send(8'hA0, 8'hFF, 8'h03, 8'h00, "R7 eeprom read");

    // R10: writes and reads dropped while busy
    send(8'hC0, 8'h00, 8'h04, 8'h11, "R10 first write");
    send(8'hC0, 8'h00, 8'h04, 8'h22, "R10 write while busy");
    wait_idle();
    send(8'hA0, 8'h00, 8'h04, 8'h00, "R10 value kept");
    send(8'h48, 8'h00, 8'h09, 8'h66, "R10 write then read");
    send(8'h28, 8'h00, 8'h09, 8'h00, "R10 read while busy");
    wait_idle();
    send(8'h28, 8'h00, 8'h09, 8'h00, "R10 read after wait");

    // R11: unknown opcode
    send(8'h55, 8'h28, 8'h09, 8'h00, "R11 unknown");

    // R5: prog_rst_n pulse clears enable
    set_prst(1'b1);
    set_prst(1'b0);
    send(8'h48, 8'h00, 8'h09, 8'h99, "R5 write after pulse");
    send(8'hAC, 8'h53, 8'h00, 8'h00, "R5 re-enable");
    send(8'h28, 8'h00, 8'h09, 8'h00, "R5 value kept");

    // R1: partial instruction discarded on pulse
    for (int j = 0; j < 12; j++) begin
      @(negedge clk); mosi = 1'b1;
      repeat (HALF) @(negedge clk); sck = 1'b1;
      repeat (HALF) @(negedge clk); sck = 1'b0;
    end
    set_prst(1'b1);
    set_prst(1'b0);
    send(8'hAC, 8'h53, 8'h00, 8'h00, "R1 enable after partial");
    send(8'hC0, 8'h00, 8'h08, 8'h4D, "R1 write after partial");
    wait_idle();
    send(8'hA0, 8'h00, 8'h08, 8'h00, "R1 read after partial");

    // R8 / R9: erase, enable dropped
    send(8'hAC, 8'h80, 8'h00, 8'h00, "R8 erase");
    wait_idle();
    send(8'hC0, 8'h00, 8'h08, 8'h21, "R9 write after erase");
    send(8'hA0, 8'h00, 8'h08, 8'h00, "R9 read after erase");
    set_prst(1'b1);
    set_prst(1'b0);
    send(8'hAC, 8'h53, 8'h00, 8'h00, "R9 re-enable");
    send(8'h28, 8'h00, 8'h07, 8'h00, "R8 flash erased");
    send(8'hA0, 8'h00, 8'h03, 8'h00, "R8 eeprom erased");
    send(8'hA0, 8'h00, 8'h08, 8'h00, "R9 eeprom untouched");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule